// File: doc/BRIEF.md
# Toggle-Flag Word Crossing

This block carries one data word, with an even-parity bit, from a source clock domain into a destination clock domain that has no phase or frequency relation to it. The word and its parity bit are never synchronized. The source loads them into a holding register and keeps that register frozen. The only signal that crosses is a single request flag. The flag changes level once per word and passes through a short synchronizer chain clocked by the receiving domain. When the receiver sees the synchronized flag change, it samples the frozen word. It then toggles an acknowledge flag, which returns to the source through a matching synchronizer.

On the source side a producer presents `src_data` together with a one-cycle `src_valid`. The word is taken only while `src_busy` is low. `src_busy` then stays high until the acknowledge comes back. On the destination side a consumer receives a one-cycle `dst_valid` strobe and the word on `dst_data`. At the same time it receives `dst_perr`, which is the recheck of the parity of the captured word and bit. The data and the parity are stored and moved as one unit, so they always belong to the same word and a parity mismatch caused by the crossing cannot occur.

The source controller has two states. SRC_IDLE moves to SRC_WAIT when a word is accepted, and this transition also toggles the request flag. SRC_WAIT moves back to SRC_IDLE when the synchronized acknowledge equals the request flag. The destination controller also has two states. DST_LISTEN moves to DST_DELIVER when the synchronized request differs from its last-seen copy; this transition captures the word and toggles the acknowledge. DST_DELIVER always returns to DST_LISTEN after one cycle. Each domain has its own active-low reset, and both flags reset to 0.

Top module: `xdom_word_mover`

## Requirements
- R1: After reset, `src_busy`, `dst_valid` and `dst_perr` are all 0.
- R2: A word presented with `src_valid` while `src_busy` is 0 is accepted, and `src_busy` is 1 from the next source clock edge.
- R3: Each accepted word appears on `dst_data` while `dst_valid` is high for exactly one destination cycle, and the value equals the accepted word.
- R4: `src_valid` while `src_busy` is 1 is ignored. No extra word is delivered, and the word in flight is delivered unchanged.
- R5: `src_busy` returns to 0 after the acknowledge is back. Words are delivered in the order they were accepted.
- R6: Parity is even: the stored bit is the XOR of all data bits. `dst_perr` is 1 only when `dst_valid` is high and the XOR of the captured word and its bit is 1. For correctly transferred words it is 0.
- R7: Exactly one `dst_valid` strobe occurs per accepted word, and two strobes are never adjacent.
- R8: Transfers are correct both when the destination clock is faster than the source clock and when it is slower.
- R9: `dst_data` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| src_valid | input | 1 | Word offered this source cycle |
| src_data | input | DATA_W | Word offered |
| src_busy | output | 1 | A transfer is in flight; offers are ignored |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| dst_valid | output | 1 | One-cycle strobe for a delivered word |
| dst_data | output | DATA_W | Delivered word, held until the next strobe |
| dst_perr | output | 1 | Parity recheck failed, valid with the strobe |

## Verification
The in-RTL assertions check the following on every cycle:
- `src_busy` rises after an acceptance.
- The request flag changes only on an acceptance.
- The holding register stays frozen while busy.
- The strobe lasts a single cycle.
- `dst_perr` is never set with a strobe.
- `dst_data` changes only with a strobe.

Only the bench scenarios can show the following:
- The delivered value equals the offered word.
- Offers made while busy really vanish at the ports.
- Order is preserved over a continuous stream.
- The count of strobes matches the count of acceptances under both a faster and a slower destination clock.

// File: rtl/xdom_pkg.sv
package xdom_pkg;

    typedef enum logic {
        SRC_IDLE,
        SRC_WAIT
    } src_state_e;

    typedef enum logic {
        DST_LISTEN,
        DST_DELIVER
    } dst_state_e;

endpackage

// File: rtl/xdom_sync.sv
module xdom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/xdom_src_ctl.sv
module xdom_src_ctl
    import xdom_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              ack_sync,
    output logic              busy,
    output logic              req_tgl,
    output logic [DATA_W:0]   hold_word
);
    src_state_e state_q, state_d;
    logic       req_q;
    logic [DATA_W:0] hold_q, hold_d;
    logic       accept;

    assign accept = (state_q == SRC_IDLE) && in_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (in_valid)          state_d = SRC_WAIT;
            SRC_WAIT: if (ack_sync == req_q) state_d = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    // load multiplexer: new word with its even-parity bit, or keep
    assign hold_d = accept ? {^in_data, in_data} : hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            req_q  <= 1'b0;
        end else begin
            hold_q <= hold_d;
            if (accept) req_q <= ~req_q;
        end
    end

    always_comb begin
        busy      = (state_q == SRC_WAIT);
        req_tgl   = req_q;
        hold_word = hold_q;
    end

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> busy);

    a_r4_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(hold_word));

    a_r7_req_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req_tgl) |-> $past(in_valid && !busy));
endmodule

// File: rtl/xdom_dst_ctl.sv
module xdom_dst_ctl
    import xdom_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync,
    input  logic [DATA_W:0]   hold_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_perr,
    output logic              ack_tgl
);
    dst_state_e state_q, state_d;
    logic       seen_q;
    logic       ack_q;
    logic [DATA_W:0] cap_q;
    logic       flag_edge;

    // third register against the synchronizer output gives the change strobe
    assign flag_edge = req_sync ^ seen_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DST_LISTEN:  if (flag_edge) state_d = DST_DELIVER;
            DST_DELIVER: state_d = DST_LISTEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DST_LISTEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            ack_q  <= 1'b0;
            cap_q  <= '0;
        end else if (state_q == DST_LISTEN) begin
            seen_q <= req_sync;
            if (flag_edge) begin
                cap_q <= hold_word;
                ack_q <= ~ack_q;
            end
        end
    end

    always_comb begin
        out_valid = (state_q == DST_DELIVER);
        out_data  = cap_q[DATA_W-1:0];
        out_perr  = out_valid && (^cap_q);
        ack_tgl   = ack_q;
    end

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r6_no_false_perr: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_perr);

    a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> out_valid);
endmodule

// File: rtl/xdom_word_mover.sv
module xdom_word_mover #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_busy,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data,
    output logic              dst_perr
);
    localparam int HOLD_W = DATA_W + 1;

    logic              req_tgl, req_sync;
    logic              ack_tgl, ack_sync;
    logic [HOLD_W-1:0] hold_word;

    xdom_src_ctl #(.DATA_W(DATA_W)) src_i (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .in_valid (src_valid),
        .in_data  (src_data),
        .ack_sync (ack_sync),
        .busy     (src_busy),
        .req_tgl  (req_tgl),
        .hold_word(hold_word)
    );

    xdom_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk  (dst_clk),
        .rst_n(dst_rst_n),
        .d    (req_tgl),
        .q    (req_sync)
    );

    xdom_dst_ctl #(.DATA_W(DATA_W)) dst_i (
        .clk      (dst_clk),
        .rst_n    (dst_rst_n),
        .req_sync (req_sync),
        .hold_word(hold_word),
        .out_valid(dst_valid),
        .out_data (dst_data),
        .out_perr (dst_perr),
        .ack_tgl  (ack_tgl)
    );

    xdom_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk  (src_clk),
        .rst_n(src_rst_n),
        .d    (ack_tgl),
        .q    (ack_sync)
    );
endmodule

// File: tb/xdom_word_mover_tb_top.sv
`timescale 1ns/1ps
module xdom_word_mover_tb_top;
    logic       src_clk = 1'b0;
    logic       dst_clk = 1'b0;
    logic       src_rst_n = 1'b0;
    logic       dst_rst_n = 1'b0;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = '0;
    logic       src_busy;
    logic       dst_valid;
    logic [7:0] dst_data;
    logic       dst_perr;

    real dst_half = 7.0;
    int  checks = 0;
    int  errors = 0;
    int  wr_cnt = 0;
    int  rd_cnt = 0;
    bit  finished = 1'b0;
    bit  prev_valid = 1'b0;
    logic [7:0] exp_mem [0:63];
    logic [7:0] last_word = '0;

    always #4 src_clk = ~src_clk;
    always #(dst_half) dst_clk = ~dst_clk;

    xdom_word_mover dut_i (
        .src_clk  (src_clk),
        .src_rst_n(src_rst_n),
        .src_valid(src_valid),
        .src_data (src_data),
        .src_busy (src_busy),
        .dst_clk  (dst_clk),
        .dst_rst_n(dst_rst_n),
        .dst_valid(dst_valid),
        .dst_data (dst_data),
        .dst_perr (dst_perr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // destination monitor, sampled on the falling edge
    always @(negedge dst_clk) begin
        if (dst_rst_n && dst_valid) begin
            chk(!prev_valid, "R7 adjacent strobes", 1, 0);
            chk(rd_cnt < wr_cnt, "R7 strobe without accepted word", rd_cnt, wr_cnt);
            if (rd_cnt < wr_cnt)
                chk(dst_data == exp_mem[rd_cnt[5:0]], "R3/R5 delivered word", dst_data, exp_mem[rd_cnt[5:0]]);
            chk(dst_perr == 1'b0, "R6 parity flag", dst_perr, 0);
            last_word = dst_data;
            rd_cnt++;
        end
        prev_valid = dst_valid;
    end

    task automatic offer(input logic [7:0] d, input bit check_busy);
        bit took;
        @(negedge src_clk);
        src_data  = d;
        src_valid = 1'b1;
        took = !src_busy;
        if (took) begin
            exp_mem[wr_cnt[5:0]] = d;
            wr_cnt++;
        end
        @(negedge src_clk);
        src_valid = 1'b0;
        if (took && check_busy) chk(src_busy == 1'b1, "R2 busy after accept", src_busy, 1);
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 400; i++) begin
            @(negedge src_clk);
            if (rd_cnt == wr_cnt && !src_busy) break;
        end
        chk(rd_cnt == wr_cnt, req, rd_cnt, wr_cnt);
        chk(src_busy == 1'b0, "R5 busy released", src_busy, 0);
    endtask

    task automatic t_reset();
        #1;
        chk(src_busy == 1'b0, "R1 busy at reset", src_busy, 0);
        chk(dst_valid == 1'b0, "R1 valid at reset", dst_valid, 0);
        chk(dst_perr == 1'b0, "R1 perr at reset", dst_perr, 0);
    endtask

    task automatic t_patterns();
        logic [7:0] pats [0:6] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80, 8'h7E, 8'h3C};
        for (int i = 0; i < 7; i++) begin
            offer(pats[i], 1'b1);
            drain("R3 each pattern delivered");
        end
    endtask

    task automatic t_busy_ignore();
        offer(8'h5A, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge src_clk);
            chk(src_busy == 1'b1, "R4 still busy", src_busy, 1);
            src_data  = 8'hC3 ^ 8'(i);
            src_valid = 1'b1;
        end
        @(negedge src_clk);
        src_valid = 1'b0;
        drain("R4 only first word delivered");
        chk(last_word == 8'h5A, "R4 in-flight word unchanged", last_word, 8'h5A);
    endtask

    task automatic t_stream();
        for (int i = 0; i < 40; i++) begin
            @(negedge src_clk);
            src_data  = 8'(8'h11 * i + 3);
            src_valid = 1'b1;
            if (!src_busy) begin
                exp_mem[wr_cnt[5:0]] = src_data;
                wr_cnt++;
            end
        end
        @(negedge src_clk);
        src_valid = 1'b0;
        drain("R5 stream order and count");
    endtask

    task automatic t_ratio(input real half, input string req);
        dst_half = half;
        offer(8'h96, 1'b1);
        drain(req);
        offer(8'h69, 1'b1);
        drain(req);
        chk(last_word == 8'h69, req, last_word, 8'h69);
    endtask

    task automatic t_hold();
        repeat (20) @(negedge dst_clk);
        chk(dst_data == last_word, "R9 data held between strobes", dst_data, last_word);
        chk(dst_valid == 1'b0, "R7 no spurious strobe", dst_valid, 0);
    endtask

    initial begin
        #3 dst_rst_n = 1'b1;
        #6;
        t_reset();
        #14 src_rst_n = 1'b1;
        t_patterns();
        t_busy_ignore();
        t_stream();
        t_ratio(2.0, "R8 fast destination");
        t_ratio(13.0, "R8 slow destination");
        t_hold();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", rd_cnt, wr_cnt);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule